// File: doc/BRIEF.md
# External Interrupt Router

This block steers a wide bank of external interrupt lines onto a small set of per-core, per-pin request outputs. Each line carries an enable bit. A rising edge on an enabled line marks it active. A falling edge on the line, or a write-one-to-clear from the core that owns the line, makes it inactive again. A per-line routing byte picks the core. A per-group routing byte, shared by 32 consecutive lines, picks one of the core's four request pins. Each output pin is the OR of the active lines routed to it.

Software reaches the block through a word-wide register port that carries a requester ID. Through this port it programs the enable bits and the two kinds of routing byte. It also reads, and clears by writing ones, the in-service bits of the core named by the requester ID. The router keeps the routing decoded into registers, which it rebuilds from the raw routing bytes on every cycle. A reload of the raw bytes therefore always yields a consistent decode. When a line that is active gets a new target core, the line moves to that core at once.

Top module: `extirq_router`

## Requirements
- R1: After reset all request outputs are low, and every enable word and routing word reads back as zero.
- R2: Routing-map word w (region 3) holds four bytes, with byte b in bits 8b+7..8b, and byte b routes line 4w+b. The target core is the index of the lowest set bit of the byte. A zero byte, or a lowest set bit at index NUM_CORE or above, targets core 0. The word reads back exactly as written.
- R3: Pin-map word w (region 1) holds one byte per group of 32 lines, with byte b routing group 4w+b. The target pin is decoded the same way as in R2, with NUM_PIN as the limit. The word reads back exactly as written.
- R4: A rising edge on an enabled line raises request output core*NUM_PIN+pin for that line's decoded core and pin. The output rises two clock edges after the input changes.
- R5: A rise on a line whose enable bit (region 0, word s/32, bit s%32) is clear marks nothing and changes no output. Setting the enable bit later, while the line stays high, does not mark the line either.
- R6: Reading in-service word w (region 2) returns, in bit s%32, the active state of line s = 32w + bit, but only for lines whose decoded core equals the requester ID.
- R7: Writing a one to in-service bit s%32 of word s/32 clears line s only when its decoded core equals the requester ID. The same write with any other ID leaves the line untouched.
- R8: A request output stays high while at least one active line is routed to it, and falls only when the last such line clears.
- R9: When an active line's routing byte changes to a different core, the line's request moves to the new core's pin. The move shows on the outputs two edges after the write, and the line is not lost.
- R10: A falling edge on a line makes it inactive regardless of its enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Interrupt line levels |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | clog2(NUM_SRC/4)+2 | Word address: region in the top two bits, word index below |
| reg_wdata | input | 32 | Write data |
| reg_rid | input | clog2(NUM_CORE) | Requester ID (core issuing the access) |
| reg_rdata | output | 32 | Read data, valid the edge after the read strobe |
| irq_out | output | NUM_CORE*NUM_PIN | Request pins, index core*NUM_PIN+pin |

## Verification
An edge on an input line marks the line on the next clock edge and reaches the request pins one edge after that. A routing or pin-map write is latched on its own edge, decoded on the following edge and seen at the pins on the one after. An in-service clear takes effect on the write edge and reaches the pins on the next edge. Read data appears on the edge that samples the read strobe. The bench drives on falling edges and waits at least two rising edges after any stimulus before it samples a pin. It takes read data at the falling edge that follows the strobe, so every sample lands after its result is due.

// File: rtl/extirq_pkg.sv
`timescale 1ns/1ps
// Shared constants, register regions and the routing-byte decode for the
// external interrupt router. Assumes routing bytes are 8 bits wide.
package extirq_pkg;

    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int GRP_SZ = 32;

    // Register regions, selected by the top two address bits.
    typedef enum logic [1:0] {
        RGN_ENABLE = 2'd0,
        RGN_PINMAP = 2'd1,
        RGN_INSVC  = 2'd2,
        RGN_ROUTE  = 2'd3
    } region_e;

    // Index of the lowest set bit; zero byte or index >= lim yields 0.
    function automatic int unsigned low_bit_sel(input logic [BYTE_W-1:0] b,
                                                input int unsigned lim);
        int unsigned r;
        r = 0;
        for (int k = BYTE_W - 1; k >= 0; k--) begin
            if (b[k]) r = k;
        end
        if (r >= lim) r = 0;
        return r;
    endfunction

endpackage

// File: rtl/extirq_route_dec.sv
`timescale 1ns/1ps
// Registered decode of the raw routing bytes into core and pin indices.
// Recomputed every cycle, so any change of the raw bytes (write or reload)
// is reflected one cycle later.
module extirq_route_dec #(
    parameter int NUM_SRC  = 256,
    parameter int NUM_GRP  = 8,
    parameter int NUM_CORE = 4,
    parameter int NUM_PIN  = 4,
    parameter int CORE_W   = 2,
    parameter int PIN_W    = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC-1:0][7:0]         route_raw,
    input  logic [NUM_GRP-1:0][7:0]         pin_raw,
    output logic [NUM_SRC-1:0][CORE_W-1:0]  core_dec,
    output logic [NUM_GRP-1:0][PIN_W-1:0]   pin_dec
);
    import extirq_pkg::*;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_core
        // Decode the target core of one line.
        always_ff @(posedge clk) begin
            if (!rst_n) core_dec[s] <= '0;
            else        core_dec[s] <= CORE_W'(low_bit_sel(route_raw[s], NUM_CORE));
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pin
        // Decode the target pin of one 32-line group.
        always_ff @(posedge clk) begin
            if (!rst_n) pin_dec[g] <= '0;
            else        pin_dec[g] <= PIN_W'(low_bit_sel(pin_raw[g], NUM_PIN));
        end
    end

endmodule

// File: rtl/extirq_src_state.sv
`timescale 1ns/1ps
// Per-line active state. A rising input edge on an enabled line sets the
// line; a falling edge or a clear request drops it. Assumes inputs are
// already synchronous to clk.
module extirq_src_state #(
    parameter int NUM_SRC = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] act
);
    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] fall;

    // Edge detection against the previous input level.
    always_comb begin
        rise = src_in & ~src_q;
        fall = ~src_in & src_q;
    end

    // Remember the previous input level.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_in;
    end

    // Set on enabled rise, drop on fall or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) act <= '0;
        else        act <= (act | (rise & en)) & ~fall & ~clr;
    end

endmodule

// File: rtl/extirq_pin_merge.sv
`timescale 1ns/1ps
// Merges the active lines onto registered request pins: each pin is the OR
// of the active lines whose decoded core and group pin select it.
module extirq_pin_merge #(
    parameter int NUM_SRC  = 256,
    parameter int NUM_GRP  = 8,
    parameter int NUM_CORE = 4,
    parameter int NUM_PIN  = 4,
    parameter int CORE_W   = 2,
    parameter int PIN_W    = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC-1:0]              act,
    input  logic [NUM_SRC-1:0][CORE_W-1:0]  core_dec,
    input  logic [NUM_GRP-1:0][PIN_W-1:0]   pin_dec,
    output logic [NUM_CORE*NUM_PIN-1:0]     irq_out
);
    import extirq_pkg::*;

    localparam int NUM_OUT = NUM_CORE * NUM_PIN;

    logic [NUM_OUT-1:0] hit;

    // Scatter each active line onto its target pin.
    always_comb begin
        int unsigned t;
        hit = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            t = int'(core_dec[s]) * NUM_PIN + int'(pin_dec[s / GRP_SZ]);
            if (act[s] && t < NUM_OUT) hit[t] = 1'b1;
        end
    end

    // Register the pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= '0;
        else        irq_out <= hit;
    end

endmodule

// File: rtl/extirq_router.sv
`timescale 1ns/1ps
// External interrupt router top: register file (enables, routing bytes,
// pin bytes, banked in-service view), line state, routing decode and pin
// merge. Assumes NUM_SRC is a multiple of 128 and NUM_CORE a power of two.
module extirq_router #(
    parameter int NUM_SRC  = 256,
    parameter int NUM_CORE = 4,
    parameter int NUM_PIN  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SRC-1:0]                src_in,
    input  logic                              reg_wr,
    input  logic                              reg_rd,
    input  logic [$clog2(NUM_SRC/4)+1:0]      reg_addr,
    input  logic [31:0]                       reg_wdata,
    input  logic [$clog2(NUM_CORE)-1:0]       reg_rid,
    output logic [31:0]                       reg_rdata,
    output logic [NUM_CORE*NUM_PIN-1:0]       irq_out
);
    import extirq_pkg::*;

    localparam int NUM_GRP  = NUM_SRC / GRP_SZ;
    localparam int IDX_W    = $clog2(NUM_SRC / 4);
    localparam int CORE_W   = $clog2(NUM_CORE);
    localparam int PIN_W    = $clog2(NUM_PIN);
    localparam int EN_WORDS = NUM_SRC / DATA_W;

    logic [NUM_SRC-1:0]             en_q;
    logic [NUM_SRC-1:0][7:0]        route_q;
    logic [NUM_GRP-1:0][7:0]        pin_q;
    logic [NUM_SRC-1:0][CORE_W-1:0] core_dec;
    logic [NUM_GRP-1:0][PIN_W-1:0]  pin_dec;
    logic [NUM_SRC-1:0]             act;
    logic [NUM_SRC-1:0]             clr_mask;
    logic [31:0]                    rd_word;
    logic [IDX_W-1:0]               widx;
    region_e                        region;

    // Split the word address into region and word index.
    always_comb begin
        widx   = reg_addr[IDX_W-1:0];
        region = region_e'(reg_addr[IDX_W +: 2]);
    end

    // Register writes to enables and raw routing bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            route_q <= '0;
            pin_q   <= '0;
        end else if (reg_wr) begin
            case (region)
                RGN_ENABLE: begin
                    for (int w = 0; w < EN_WORDS; w++)
                        if (widx == IDX_W'(w)) en_q[w*DATA_W +: DATA_W] <= reg_wdata;
                end
                RGN_ROUTE: begin
                    for (int s = 0; s < NUM_SRC; s++)
                        if (widx == IDX_W'(s / 4)) route_q[s] <= reg_wdata[(s % 4)*BYTE_W +: BYTE_W];
                end
                RGN_PINMAP: begin
                    for (int g = 0; g < NUM_GRP; g++)
                        if (widx == IDX_W'(g / 4)) pin_q[g] <= reg_wdata[(g % 4)*BYTE_W +: BYTE_W];
                end
                default: ;
            endcase
        end
    end

    // Write-one-to-clear, limited to lines owned by the requesting core.
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            clr_mask[s] = reg_wr && (region == RGN_INSVC) &&
                          (widx == IDX_W'(s / DATA_W)) &&
                          reg_wdata[s % DATA_W] && (core_dec[s] == reg_rid);
        end
    end

    // Read mux over the four regions.
    always_comb begin
        rd_word = '0;
        case (region)
            RGN_ENABLE: begin
                for (int w = 0; w < EN_WORDS; w++)
                    if (widx == IDX_W'(w)) rd_word = en_q[w*DATA_W +: DATA_W];
            end
            RGN_ROUTE: begin
                for (int s = 0; s < NUM_SRC; s++)
                    if (widx == IDX_W'(s / 4)) rd_word[(s % 4)*BYTE_W +: BYTE_W] = route_q[s];
            end
            RGN_PINMAP: begin
                for (int g = 0; g < NUM_GRP; g++)
                    if (widx == IDX_W'(g / 4)) rd_word[(g % 4)*BYTE_W +: BYTE_W] = pin_q[g];
            end
            RGN_INSVC: begin
                for (int s = 0; s < NUM_SRC; s++)
                    if (widx == IDX_W'(s / DATA_W))
                        rd_word[s % DATA_W] = act[s] && (core_dec[s] == reg_rid);
            end
            default: ;
        endcase
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_word;
    end

    extirq_route_dec #(
        .NUM_SRC(NUM_SRC), .NUM_GRP(NUM_GRP), .NUM_CORE(NUM_CORE),
        .NUM_PIN(NUM_PIN), .CORE_W(CORE_W), .PIN_W(PIN_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n),
        .route_raw(route_q), .pin_raw(pin_q),
        .core_dec(core_dec), .pin_dec(pin_dec)
    );

    extirq_src_state #(
        .NUM_SRC(NUM_SRC)
    ) u_state (
        .clk(clk), .rst_n(rst_n),
        .src_in(src_in), .en(en_q), .clr(clr_mask), .act(act)
    );

    extirq_pin_merge #(
        .NUM_SRC(NUM_SRC), .NUM_GRP(NUM_GRP), .NUM_CORE(NUM_CORE),
        .NUM_PIN(NUM_PIN), .CORE_W(CORE_W), .PIN_W(PIN_W)
    ) u_merge (
        .clk(clk), .rst_n(rst_n),
        .act(act), .core_dec(core_dec), .pin_dec(pin_dec),
        .irq_out(irq_out)
    );

endmodule

// File: rtl/extirq_router_chk.sv
`timescale 1ns/1ps
// Property checker for the external interrupt router, bound to the top.
// Relates line inputs, enables, clear requests, active state and pins.
module extirq_router_chk #(
    parameter int NUM_SRC = 256,
    parameter int NUM_OUT = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_in,
    input logic [NUM_SRC-1:0] en,
    input logic [NUM_SRC-1:0] clr,
    input logic [NUM_SRC-1:0] act,
    input logic [NUM_OUT-1:0] irq_out
);
    logic past_ok;

    // Marks that one clock has passed out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R5
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((act & ~$past(act) & ~$past(en)) == '0));

    // R10
    line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((act & ~$past(src_in)) == '0));

    // R7
    clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(|clr)) |-> ((act & $past(clr)) == '0));

    // R8
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ($past(act) == '0)) |-> (irq_out == '0));

    // R8
    pin_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ($countones(irq_out) <= $countones($past(act))));

endmodule

bind extirq_router extirq_router_chk #(
    .NUM_SRC(NUM_SRC), .NUM_OUT(NUM_CORE*NUM_PIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .en(en_q),
    .clr(clr_mask), .act(act), .irq_out(irq_out)
);

// File: tb/extirq_router_test.sv
`timescale 1ns/1ps
// Sweeping bench for the external interrupt router (256 lines, 4 cores,
// 4 pins). Expected routing is computed from the byte rules in the bench.
module extirq_router_test;

    localparam int NSRC = 256;
    localparam int NCORE = 4;
    localparam int NPIN = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic         wr = 1'b0;
    logic         rd = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [1:0]   rid = '0;
    logic [31:0]  rdata;
    logic [15:0]  irq;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    extirq_router #(.NUM_SRC(NSRC), .NUM_CORE(NCORE), .NUM_PIN(NPIN)) uut (
        .clk(clk), .rst_n(rst_n), .src_in(src), .reg_wr(wr), .reg_rd(rd),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rid(rid),
        .reg_rdata(rdata), .irq_out(irq)
    );

    function automatic int pick(input logic [7:0] v, input int lim);
        for (int k = 0; k < 8; k++) if (v[k]) return (k < lim) ? k : 0;
        return 0;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    task automatic wreg(input logic [1:0] rg, input int w, input logic [31:0] d, input logic [1:0] id);
        addr = {rg, 6'(w)}; wdata = d; rid = id; wr = 1'b1;
        @(posedge clk); @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] rg, input int w, input logic [1:0] id, output logic [31:0] d);
        addr = {rg, 6'(w)}; rid = id; rd = 1'b1;
        @(posedge clk); @(negedge clk);
        rd = 1'b0; d = rdata;
    endtask

    initial begin
        logic [31:0] r;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 pins", 32'(irq), 0);
        rreg(2'd0, 0, 0, r); chk("R1 enable", r, 0);
        rreg(2'd3, 0, 0, r); chk("R1 route", r, 0);
        rreg(2'd1, 0, 0, r); chk("R1 pinmap", r, 0);

        // R4 enabled rise raises core0 pin0
        wreg(2'd0, 0, 32'hffff_ffff, 0);
        src[0] = 1'b1; tick(2);
        chk("R4 rise", 32'(irq), 32'h1);
        rreg(2'd2, 0, 0, r); chk("R6 own core", r, 32'h1);
        rreg(2'd2, 0, 1, r); chk("R6 other core", r, 32'h0);

        // R2 / R9 sweep of routing byte with the line active
        for (int v = 0; v < 256; v++) begin
            wreg(2'd3, 0, 32'(v), 0); tick(2);
            chk("R9 live move", 32'(irq), 32'(1) << (NPIN * pick(8'(v), NCORE)));
            rreg(2'd3, 0, 0, r); chk("R2 readback", r, 32'(v));
        end

        wreg(2'd3, 0, 32'h04, 0); tick(2);
        chk("R2 core2", 32'(irq), 32'h100);
        rreg(2'd2, 0, 2, r); chk("R6 core2 view", r, 32'h1);
        rreg(2'd2, 0, 0, r); chk("R6 core0 view", r, 32'h0);

        // R7 clear only by owner
        wreg(2'd2, 0, 32'h1, 0); tick(2);
        chk("R7 foreign clear", 32'(irq), 32'h100);
        rreg(2'd2, 0, 2, r); chk("R7 still set", r, 32'h1);
        wreg(2'd2, 0, 32'h1, 2); tick(2);
        chk("R7 owner clear", 32'(irq), 32'h0);
        rreg(2'd2, 0, 2, r); chk("R7 bit gone", r, 32'h0);
        src[0] = 1'b0; tick(2);
        wreg(2'd3, 0, 32'h0, 0);

        // R3 sweep of the pin byte of group 1 (line 33)
        wreg(2'd0, 1, 32'hffff_ffff, 0);
        src[33] = 1'b1; tick(2);
        chk("R3 default pin", 32'(irq), 32'h1);
        for (int v = 0; v < 256; v++) begin
            wreg(2'd1, 0, 32'(v) << 8, 0); tick(2);
            chk("R3 pin select", 32'(irq), 32'(1) << pick(8'(v), NPIN));
            rreg(2'd1, 0, 0, r); chk("R3 readback", r, 32'(v) << 8);
        end
        // R10 fall drops the line
        src[33] = 1'b0; tick(2);
        chk("R10 fall", 32'(irq), 32'h0);

        // R5 disabled rise ignored, late enable does not mark
        wreg(2'd0, 1, 32'h0, 0);
        src[40] = 1'b1; tick(2);
        chk("R5 disabled pins", 32'(irq), 32'h0);
        rreg(2'd2, 1, 0, r); chk("R5 disabled insvc", r, 32'h0);
        wreg(2'd0, 1, 32'hffff_ffff, 0); tick(2);
        chk("R5 late enable", 32'(irq), 32'h0);
        src[40] = 1'b0; tick(2);

        // R8 shared pin stays up until last line clears
        src[34] = 1'b1; tick(2); chk("R8 first", 32'(irq), 32'h1);
        src[35] = 1'b1; tick(2); chk("R8 second", 32'(irq), 32'h1);
        src[34] = 1'b0; tick(2); chk("R8 one left", 32'(irq), 32'h1);
        src[35] = 1'b0; tick(2); chk("R8 last gone", 32'(irq), 32'h0);

        // R2 byte order: lines 4..7 to cores 0..3
        wreg(2'd3, 1, 32'h0804_0201, 0); tick(2);
        for (int b = 0; b < 4; b++) begin
            src[4+b] = 1'b1; tick(2);
            chk("R2 byte order", 32'(irq), 32'(1) << (NPIN * b));
            src[4+b] = 1'b0; tick(2);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        done = 1;
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule